// File: doc/BRIEF.md
# Limit-Match Counter/Timer

This block is a memory-mapped counter/timer with a 32-bit register view. An internal count advances by one unit on every cycle in which the tick enable input is high. The system supplies that enable once per 500 ns. The count sits in the upper part of a word whose nine least significant bits always read as zero.

Software programs a limit. When the next count would equal that limit, the count reloads to zero on that tick and a sticky reached flag is set. A level interrupt is raised at the same time. Reading the limit back acknowledges the event. A limit of zero turns the block into a plain free-running counter that wraps and never interrupts.

Two limit write offsets exist. One restarts the count and the other leaves it running. Register accesses are single-cycle strobes on a word address. The block accepts an access on every cycle and never applies back-pressure. Read data comes back registered, qualified by a valid pulse exactly one cycle after the read strobe. A write and a read may be issued together.

Top module: `lmt_timer`

## Requirements
- R1: The count field is bits [FRAC_W+CNT_W-1:FRAC_W] of the counter word, which is bits 30..9 with the default CNT_W=22. It increments by one unit per cycle with tick_i high, and bits 8..0 of every read value are zero.
- R2: When a tick would take the count to a nonzero limit, bit 31 (reached) of the counter word is set and irq_o rises. Both take effect on the register update of that tick, and irq_o never rises otherwise.
- R3: A write to word offset 0 stores the write data masked to the count field bits as the new limit. Data with only bits 8..0 set stores a limit of zero.
- R4: With a limit of zero the count wraps from its all-ones value (0x7FFFFE00 with defaults) to zero. The reached flag is not set and irq_o does not rise.
- R5: A write to offset 0 sets the count to zero and lowers irq_o, and it leaves the reached flag unchanged. The restart takes priority over a tick in the same cycle.
- R6: A write to offset 2 stores a new limit, masked as in R3, without changing the count.
- R7: A read of offset 0 returns the limit with bit 31 zero. It clears the reached flag and lowers irq_o, unless a match occurs in the same cycle, in which case the match wins.
- R8: After reset the limit is zero, the count is zero, reached is clear, irq_o is low, and the counter runs free.
- R9: After a match the count restarts from zero and the period repeats. irq_o stays high until it is acknowledged by R7 or lowered by R5.
- R10: Reads of offsets other than 0 and 1 return zero. Writes to offset 1 and to offsets other than 0 and 2 change no state.
- R11: bus_rvalid_o is high exactly in the cycle after each cycle with bus_rd_i high, and bus_rdata_o carries the value selected at the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle enable per 500 ns count step |
| bus_addr_i | input | ADDR_W | Word offset of the access |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after bus_rd_i |
| irq_o | output | 1 | Level interrupt on limit match |

## Verification
The bench builds the block with CNT_W=8 and keeps ADDR_W at its default of 3. With the narrower field, the free-run wrap from the all-ones count back to zero takes only 256 ticks. A wrap past the maximum after a masked zero limit also fits in a short run. The same configuration covers masking: a limit bit above the field is dropped, and a write with only bits 8..0 set falls back to free-run.

// File: rtl/lmt_pkg.sv
package lmt_pkg;
  localparam int DATA_W = 32;
  localparam int FRAC_W = 9;

  localparam int OFS_LIMIT      = 0;
  localparam int OFS_COUNT      = 1;
  localparam int OFS_LIMIT_KEEP = 2;

  typedef enum logic [1:0] {
    RSEL_ZERO  = 2'd0,
    RSEL_LIMIT = 2'd1,
    RSEL_COUNT = 2'd2
  } rsel_e;
endpackage

// File: rtl/lmt_decode.sv
module lmt_decode
  import lmt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              ld_restart_o,
  output logic              ld_keep_o,
  output logic              ack_o,
  output rsel_e             rsel_o
);
  logic hit_limit, hit_count, hit_keep;

  always_comb begin
    hit_limit    = (addr_i == ADDR_W'(OFS_LIMIT));
    hit_count    = (addr_i == ADDR_W'(OFS_COUNT));
    hit_keep     = (addr_i == ADDR_W'(OFS_LIMIT_KEEP));
    ld_restart_o = wr_i & hit_limit;
    ld_keep_o    = wr_i & hit_keep;
    ack_o        = rd_i & hit_limit;
    if (hit_limit)      rsel_o = RSEL_LIMIT;
    else if (hit_count) rsel_o = RSEL_COUNT;
    else                rsel_o = RSEL_ZERO;
  end
endmodule

// File: rtl/lmt_count.sv
module lmt_count #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ld_restart_i,
  input  logic             ld_keep_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] lim_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q, lim_q, cnt_inc;

  always_comb begin
    cnt_inc = cnt_q + 1'b1;
    match_o = tick_i && !ld_restart_i && (lim_q != '0) && (cnt_inc == lim_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      if (ld_restart_i || ld_keep_i) lim_q <= ld_val_i;
      if (ld_restart_i)              cnt_q <= '0;
      else if (match_o)              cnt_q <= '0;
      else if (tick_i)               cnt_q <= cnt_inc;
    end
  end

  assign cnt_o = cnt_q;
  assign lim_o = lim_q;

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ld_restart_i |=> (cnt_q == '0)); // R5
  AST_KEEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_keep_i && !tick_i) |=> (cnt_q == $past(cnt_q))); // R6
  AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> (cnt_q == '0)); // R9
  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ld_restart_i && lim_q == '0) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R4
endmodule

// File: rtl/lmt_flags.sv
module lmt_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic match_i,
  input  logic ack_i,
  input  logic ld_restart_i,
  output logic reached_o,
  output logic irq_o
);
  logic reached_q, irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (match_i)    reached_q <= 1'b1;
      else if (ack_i) reached_q <= 1'b0;
      if (match_i)                    irq_q <= 1'b1;
      else if (ack_i || ld_restart_i) irq_q <= 1'b0;
    end
  end

  assign reached_o = reached_q;
  assign irq_o     = irq_q;

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !ack_i && !ld_restart_i) |=> irq_q); // R9
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !match_i) |=> (!reached_q && !irq_q)); // R7
  AST_IRQ_ONLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && !match_i) |=> !irq_q); // R2
  AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    match_i |=> (reached_q && irq_q)); // R2
endmodule

// File: rtl/lmt_readback.sv
module lmt_readback
  import lmt_pkg::*;
#(
  parameter int CNT_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  rsel_e             rsel_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  lim_i,
  input  logic              reached_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (rsel_i)
      RSEL_LIMIT: rd_mux[FRAC_W +: CNT_W] = lim_i;
      RSEL_COUNT: begin
        rd_mux[FRAC_W +: CNT_W] = cnt_i;
        rd_mux[DATA_W-1]        = reached_i;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= rd_mux;
    end
  end

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |-> (rdata_o[FRAC_W-1:0] == '0)); // R1
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && rsel_i == RSEL_ZERO) |=> (rdata_o == '0)); // R10
  AST_RVALID_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rvalid_o); // R11
endmodule

// File: rtl/lmt_timer.sv
module lmt_timer
  import lmt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] LIM_MASK = DATA_W'(((64'd1 << CNT_W) - 1) << FRAC_W);

  logic             ld_restart, ld_keep, ack, match, reached;
  logic [CNT_W-1:0] cnt, lim;
  rsel_e            rsel;
  logic             unused_wdata;

  assign unused_wdata = ^(bus_wdata_i & ~LIM_MASK);

  lmt_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i(bus_addr_i), .wr_i(bus_wr_i), .rd_i(bus_rd_i),
    .ld_restart_o(ld_restart), .ld_keep_o(ld_keep), .ack_o(ack), .rsel_o(rsel)
  );

  lmt_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .ld_restart_i(ld_restart), .ld_keep_i(ld_keep),
    .ld_val_i(bus_wdata_i[FRAC_W +: CNT_W]),
    .cnt_o(cnt), .lim_o(lim), .match_o(match)
  );

  lmt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .match_i(match), .ack_i(ack),
    .ld_restart_i(ld_restart), .reached_o(reached), .irq_o(irq_o)
  );

  lmt_readback #(.CNT_W(CNT_W)) u_readback (
    .clk(clk), .rst_n(rst_n), .rd_i(bus_rd_i), .rsel_i(rsel),
    .cnt_i(cnt), .lim_i(lim), .reached_i(reached),
    .rdata_o(bus_rdata_o), .rvalid_o(bus_rvalid_o)
  );

  AST_FREE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (lim == '0 && !irq_o) |=> !irq_o); // R4
  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(tick_i)); // R2
endmodule

// File: tb/lmt_timer_tb.sv
`timescale 1ns/1ps
module lmt_timer_tb;
  localparam int CNT_W = 8;
  localparam int ADDR_W = 3;
  localparam logic [31:0] LMASK = 32'(((1 << CNT_W) - 1) << 9);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid, irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  lmt_timer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .irq_o(irq)
  );

  function automatic logic [31:0] u(input int n);
    return 32'(n) << 9;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        chk(32'd1, 32'd0, "R11 unexpected rvalid");
      end else begin
        chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic do_read(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = ADDR_W'(a); rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic do_write(input int a, input logic [31:0] d, input logic t);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = d; wr = 1'b1; tick = t;
    @(negedge clk);
    wr = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    chk(32'(irq), 32'd0, "R8 irq after reset");
    do_read(0, 32'd0, "R8 limit after reset");
    do_read(1, 32'd0, "R8 count after reset");
    // R1 counting
    ticks(5);
    do_read(1, u(5), "R1 count after 5 ticks");
    // R4 free-run wrap
    ticks(250);
    do_read(1, u(255), "R4 count at max");
    ticks(1);
    do_read(1, 32'd0, "R4 wrap to zero, no reached");
    chk(32'(irq), 32'd0, "R4 no irq on wrap");
    // R3 masked limit, R5 restart
    ticks(3);
    do_write(0, 32'h8010_15FF, 1'b0);
    do_read(1, 32'd0, "R5 restart on limit write");
    do_read(0, 32'h8010_15FF & LMASK, "R3 masked limit readback");
    // R2 match, R9 reload
    ticks(9);
    chk(32'(irq), 32'd0, "R2 no irq before match");
    ticks(1);
    chk(32'(irq), 32'd1, "R2 irq on match");
    do_read(1, 32'h8000_0000, "R9 reload to zero with reached");
    ticks(3);
    do_read(1, 32'h8000_0000 | u(3), "R9 counting after reload");
    chk(32'(irq), 32'd1, "R9 irq held");
    // R7 acknowledge
    do_read(0, u(10), "R7 limit read");
    chk(32'(irq), 32'd0, "R7 irq lowered by ack");
    do_read(1, u(3), "R7 reached cleared");
    // R6 limit write keeps count
    ticks(2);
    do_write(2, u(20), 1'b0);
    do_read(1, u(5), "R6 count kept");
    ticks(14);
    chk(32'(irq), 32'd0, "R6 no irq before new limit");
    ticks(1);
    chk(32'(irq), 32'd1, "R6 match at new limit");
    do_read(0, u(20), "R6 new limit readback");
    // R5 write lowers irq, keeps reached
    ticks(20);
    chk(32'(irq), 32'd1, "R9 periodic match");
    do_write(0, u(4), 1'b0);
    chk(32'(irq), 32'd0, "R5 irq lowered by limit write");
    do_read(1, 32'h8000_0000, "R5 reached kept, count zero");
    do_read(0, u(4), "R7 ack");
    // R10 ignored writes and unmapped reads
    ticks(2);
    do_write(1, 32'h0001_2600, 1'b0);
    do_read(1, u(2), "R10 counter write ignored");
    do_write(5, 32'h0000_3000, 1'b0);
    do_read(0, u(4), "R10 unmapped write ignored");
    do_read(5, 32'd0, "R10 unmapped read zero");
    do_read(3, 32'd0, "R10 offset 3 read zero");
    // R4 offset 2 to zero: free run
    do_write(2, 32'd0, 1'b0);
    ticks(10);
    chk(32'(irq), 32'd0, "R4 free-run past old limit");
    do_read(1, u(12), "R4 free-run count");
    // R3 low-bit-only limit becomes free-run
    do_write(0, 32'h0000_01FF, 1'b0);
    do_read(0, 32'd0, "R3 low bits masked to zero limit");
    ticks(300);
    chk(32'(irq), 32'd0, "R4 no irq over wrap");
    do_read(1, u(44), "R4 count after wrap");
    // R5 restart wins over tick
    do_write(0, 32'd0, 1'b1);
    do_read(1, 32'd0, "R5 restart beats tick");
    repeat (3) @(negedge clk);
    chk(32'(exp_q.size()), 32'd0, "R11 all reads returned");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule